// File: doc/BRIEF.md
# Two-Way Lockable Cache Lookup

This block holds the tags and data of a 4-Kbyte cache. The cache has two ways of 128 sets, and each line holds four 32-bit words. A core presents a physical read address. The block answers with a hit and the addressed word, or it treats the access as a miss. On a miss it asks the external memory side for the whole line, takes in four words, and then answers with the word the core asked for. The line is installed in a victim way. The victim comes from a one-bit least-recently-used record kept per set.

Software-style commands act on the line that an address names. A command can pin that line so that replacement never evicts it, release the pin, or drop the line altogether. When both ways of a set are pinned, a miss to that set is still served from the fill data. Nothing is installed, and the response carries a no-allocate flag. The block handles one request or command at a time, and `busy` is high while a lookup or fill is in progress.

Top module: `cache2w_lookup`

## Requirements
- R1: A 32-bit byte address splits into tag bits [31:11], set index bits [10:4] and word select bits [3:2]. Bits [1:0] are ignored. A hit returns the addressed word with `rsp_hit`=1 and `rsp_noalloc`=0.
- R2: On a miss the block raises `fill_req` with `fill_addr` set to the line address (bits [3:0] zero). It consumes exactly four `fill_valid` words in ascending word order, tolerates gaps between them, and answers with `rsp_hit`=0 and the requested word once the fourth word arrives.
- R3: A line being filled is not valid until its fourth word is written. After the fill, every word of the line hits with the data the fill delivered.
- R4: Victim choice within a set follows this order. An invalid way is taken first, way 0 before way 1. Otherwise the way named by the set's LRU bit is taken. The LRU bit is set to the other way on every hit and on every allocating fill.
- R5: `cmd_op`=1 with `cmd_valid` locks the line at `cmd_addr` if that line is present. A locked line is never chosen as victim. When one way is locked, every miss to the set replaces the other way.
- R6: When both ways of a set are locked, a miss returns the correct word with `rsp_noalloc`=1. It changes no line and no LRU state, so both locked lines still hit and the missed line misses again.
- R7: `cmd_op`=2 clears the lock of the addressed line and leaves the line valid. That way becomes eligible for replacement again.
- R8: `cmd_op`=3 clears the valid and lock bits of the addressed line, so the next access to it misses. `cmd_op`=0 does nothing. A command in the same cycle as a request takes priority, and the request is not accepted.
- R9: After reset, `rsp_valid`, `fill_req` and `busy` are low and every line is invalid.
- R10: `rsp_valid` is a single-cycle pulse for each accepted request. At most one way matches a lookup, and a hit never reports no-allocate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Read request, accepted when `busy` is low and no command is present |
| req_addr | input | 32 | Physical byte address of the read |
| busy | output | 1 | Lookup or fill in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from the array |
| rsp_noalloc | output | 1 | Miss served without allocation (both ways locked) |
| rsp_data | output | 32 | Requested word |
| fill_req | output | 1 | Line fill wanted |
| fill_addr | output | 32 | Line-aligned fill address |
| fill_valid | input | 1 | One fill word present |
| fill_data | input | 32 | Fill word, ascending order |
| cmd_valid | input | 1 | Line command strobe, taken when `busy` is low |
| cmd_op | input | 2 | 0 none, 1 lock, 2 unlock, 3 invalidate |
| cmd_addr | input | 32 | Address naming the target line |

## Verification
The assertions check, on every cycle, the properties that hold locally. At most one way matches. A locked way never reaches the victim output unless the set is fully locked, and the no-allocate indication only appears with both locks set. The way being filled stays invalid until the fill ends. Responses are single-cycle pulses, and fill addresses are line aligned. Other behaviour only shows up over several accesses, and the bench's scenarios are what demonstrate it. This covers the LRU order across a sequence of accesses and the return of correct words after a fill. It also covers lock and unlock effects on later misses, no-allocate misses that leave the set untouched, and invalidation. The bench compares all of these against a reference model over directed and pseudo-random sequences.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  typedef enum logic [1:0] {
    CMD_NOP    = 2'd0,
    CMD_LOCK   = 2'd1,
    CMD_UNLOCK = 2'd2,
    CMD_INVAL  = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } state_e;

endpackage

// File: rtl/cache2w_tagstore.sv
module cache2w_tagstore #(
  parameter int SETS  = 128,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output logic [1:0]       hit_vec,
  output logic [1:0]       valid_vec,
  output logic [1:0]       lock_vec,
  output logic             lru_bit,
  input  logic             tag_we,
  input  logic             tag_way,
  input  logic             clr_we,
  input  logic             clr_way,
  input  logic             lock_we,
  input  logic             lock_way,
  input  logic             lock_val,
  input  logic             lru_we,
  input  logic             lru_val
);

  logic lru_q [SETS];

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic             valid_q [SETS];
    logic             lock_q  [SETS];
    logic [TAG_W-1:0] tag_q   [SETS];

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) begin
          valid_q[s] <= 1'b0;
          lock_q[s]  <= 1'b0;
        end
      end else begin
        if (clr_we && clr_way == 1'(w)) begin
          valid_q[idx] <= 1'b0;
          lock_q[idx]  <= 1'b0;
        end
        if (tag_we && tag_way == 1'(w)) begin
          valid_q[idx] <= 1'b1;
        end
        if (lock_we && lock_way == 1'(w)) begin
          lock_q[idx] <= lock_val;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (tag_we && tag_way == 1'(w)) begin
        tag_q[idx] <= tag;
      end
    end

    assign valid_vec[w] = valid_q[idx];
    assign lock_vec[w]  = lock_q[idx];
    assign hit_vec[w]   = valid_q[idx] && (tag_q[idx] == tag);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= 1'b0;
    end else if (lru_we) begin
      lru_q[idx] <= lru_val;
    end
  end

  assign lru_bit = lru_q[idx];

endmodule

// File: rtl/cache2w_victim.sv
module cache2w_victim (
  input  logic [1:0] valid_vec,
  input  logic [1:0] lock_vec,
  input  logic       lru_bit,
  output logic       victim_way,
  output logic       no_alloc
);

  always_comb begin
    no_alloc   = 1'b0;
    victim_way = lru_bit;
    if (&lock_vec) begin
      no_alloc = 1'b1;
    end else if (lock_vec[0]) begin
      victim_way = 1'b1;
    end else if (lock_vec[1]) begin
      victim_way = 1'b0;
    end else if (!valid_vec[0]) begin
      victim_way = 1'b0;
    end else if (!valid_vec[1]) begin
      victim_way = 1'b1;
    end
  end

endmodule

// File: rtl/cache2w_datastore.sv
module cache2w_datastore #(
  parameter int SETS   = 128,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WSEL_W = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   wr_en,
  input  logic                   wr_way,
  input  logic [WSEL_W-1:0]      wr_word,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [WSEL_W-1:0]      rd_word,
  output logic [1:0][DATA_W-1:0] rd_data
);

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DATA_W-1:0] mem_q [SETS][WORDS];

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == 1'(w)) begin
        mem_q[idx][wr_word] <= wr_data;
      end
    end

    assign rd_data[w] = mem_q[idx][rd_word];
  end

endmodule

// File: rtl/cache2w_lookup.sv
module cache2w_lookup #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 128,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_noalloc,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr
);
  import cache2w_pkg::*;

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = WSEL_W + BYTE_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS - 1);

  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  state_e              state_q, state_d;
  logic [LINE_W-1:0]   line_q, line_d;
  logic [WSEL_W-1:0]   wsel_q, wsel_d;
  logic [WSEL_W-1:0]   cnt_q, cnt_d;
  logic                vway_q, vway_d;
  logic                noal_q, noal_d;
  logic [DATA_W-1:0]   cap_q, cap_d;
  logic                rspv_q, rspv_d;
  logic                rsph_q, rsph_d;
  logic                rspn_q, rspn_d;
  logic [DATA_W-1:0]   rspd_q, rspd_d;

  logic [IDX_W-1:0]    lk_idx;
  logic [TAG_W-1:0]    lk_tag;
  logic [1:0]          hit_vec, valid_vec, lock_vec;
  logic                lru_bit, victim_way, no_alloc;
  logic                hit_any, hit_way;
  logic                tag_we, clr_we, clr_way, lock_we, lock_val, lru_we, lru_val;
  logic                dat_we;
  logic [1:0][DATA_W-1:0] rd_data;
  logic                unused_bits;

  assign unused_bits = ^{cmd_addr[OFF_W-1:0], req_addr[BYTE_W-1:0]};

  // one shared compare port: commands use it while idle, requests afterwards
  always_comb begin
    if (state_q == ST_IDLE) begin
      lk_idx = cmd_addr[OFF_W +: IDX_W];
      lk_tag = cmd_addr[ADDR_W-1 -: TAG_W];
    end else begin
      lk_idx = line_q[IDX_W-1:0];
      lk_tag = line_q[LINE_W-1 -: TAG_W];
    end
  end

  cache2w_tagstore #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .idx       (lk_idx),
    .tag       (lk_tag),
    .hit_vec   (hit_vec),
    .valid_vec (valid_vec),
    .lock_vec  (lock_vec),
    .lru_bit   (lru_bit),
    .tag_we    (tag_we),
    .tag_way   (vway_q),
    .clr_we    (clr_we),
    .clr_way   (clr_way),
    .lock_we   (lock_we),
    .lock_way  (hit_way),
    .lock_val  (lock_val),
    .lru_we    (lru_we),
    .lru_val   (lru_val)
  );

  cache2w_victim u_victim (
    .valid_vec  (valid_vec),
    .lock_vec   (lock_vec),
    .lru_bit    (lru_bit),
    .victim_way (victim_way),
    .no_alloc   (no_alloc)
  );

  cache2w_datastore #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .idx     (line_q[IDX_W-1:0]),
    .wr_en   (dat_we),
    .wr_way  (vway_q),
    .wr_word (cnt_q),
    .wr_data (fill_data),
    .rd_word (wsel_q),
    .rd_data (rd_data)
  );

  assign hit_any = |hit_vec;
  assign hit_way = hit_vec[1];

  // next-state logic
  always_comb begin
    state_d  = state_q;
    line_d   = line_q;
    wsel_d   = wsel_q;
    cnt_d    = cnt_q;
    vway_d   = vway_q;
    noal_d   = noal_q;
    cap_d    = cap_q;
    rspv_d   = 1'b0;
    rsph_d   = rsph_q;
    rspn_d   = rspn_q;
    rspd_d   = rspd_q;
    tag_we   = 1'b0;
    clr_we   = 1'b0;
    clr_way  = hit_way;
    lock_we  = 1'b0;
    lock_val = 1'b0;
    lru_we   = 1'b0;
    lru_val  = 1'b0;
    dat_we   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          case (cmd_op_e'(cmd_op))
            CMD_LOCK: begin
              lock_we  = hit_any;
              lock_val = 1'b1;
            end
            CMD_UNLOCK: lock_we = hit_any;
            CMD_INVAL:  clr_we  = hit_any;
            default: ;
          endcase
        end else if (req_valid) begin
          line_d  = req_addr[ADDR_W-1:OFF_W];
          wsel_d  = req_addr[OFF_W-1:BYTE_W];
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (hit_any) begin
          rspv_d  = 1'b1;
          rsph_d  = 1'b1;
          rspn_d  = 1'b0;
          rspd_d  = rd_data[hit_way];
          lru_we  = 1'b1;
          lru_val = ~hit_way;
          state_d = ST_IDLE;
        end else begin
          vway_d  = victim_way;
          noal_d  = no_alloc;
          cnt_d   = '0;
          clr_we  = ~no_alloc;
          clr_way = victim_way;
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (fill_valid) begin
          dat_we = ~noal_q;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == wsel_q) cap_d = fill_data;
          if (cnt_q == LAST_WORD) begin
            tag_we  = ~noal_q;
            lru_we  = ~noal_q;
            lru_val = ~vway_q;
            rspv_d  = 1'b1;
            rsph_d  = 1'b0;
            rspn_d  = noal_q;
            rspd_d  = (cnt_q == wsel_q) ? fill_data : cap_q;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rspv_q  <= 1'b0;
      rsph_q  <= 1'b0;
      rspn_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rspv_q  <= rspv_d;
      rsph_q  <= rsph_d;
      rspn_q  <= rspn_d;
    end
  end

  // datapath registers
  always_ff @(posedge clk) begin
    line_q <= line_d;
    wsel_q <= wsel_d;
    vway_q <= vway_d;
    noal_q <= noal_d;
    cap_q  <= cap_d;
    rspd_q <= rspd_d;
  end

  assign busy        = (state_q != ST_IDLE);
  assign fill_req    = (state_q == ST_FILL);
  assign fill_addr   = {line_q, {OFF_W{1'b0}}};
  assign rsp_valid   = rspv_q;
  assign rsp_hit     = rsph_q;
  assign rsp_noalloc = rspn_q;
  assign rsp_data    = rspd_q;

endmodule

// File: rtl/cache2w_lookup_chk.sv
module cache2w_lookup_chk #(
  parameter int OFF_W = 4
) (
  input logic                clk,
  input logic                rst_ni,
  input cache2w_pkg::state_e state_q,
  input logic [1:0]          hit_vec,
  input logic [1:0]          valid_vec,
  input logic [1:0]          lock_vec,
  input logic                victim_way,
  input logic                no_alloc,
  input logic                noal_q,
  input logic                vway_q,
  input logic                rsp_valid,
  input logic                rsp_hit,
  input logic                rsp_noalloc,
  input logic                fill_req,
  input logic [OFF_W-1:0]    fill_off
);
  import cache2w_pkg::*;

  assert_one_way_match_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    state_q != ST_FILL |-> $onehot0(hit_vec));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |=> !rsp_valid);

  assert_hit_allocates_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && rsp_hit) |-> !rsp_noalloc);

  assert_locked_not_victim_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_LOOK && hit_vec == 2'b00 && !no_alloc) |-> !lock_vec[victim_way]);

  assert_noalloc_both_locked_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_LOOK && no_alloc) |-> (lock_vec == 2'b11));

  assert_filling_way_invalid_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_FILL && !noal_q) |-> !valid_vec[vway_q]);

  assert_fill_aligned_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    fill_req |-> (fill_off == '0));

endmodule

bind cache2w_lookup cache2w_lookup_chk #(.OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_ni),
  .state_q     (state_q),
  .hit_vec     (hit_vec),
  .valid_vec   (valid_vec),
  .lock_vec    (lock_vec),
  .victim_way  (victim_way),
  .no_alloc    (no_alloc),
  .noal_q      (noal_q),
  .vway_q      (vway_q),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_noalloc (rsp_noalloc),
  .fill_req    (fill_req),
  .fill_off    (fill_addr[OFF_W-1:0])
);

// File: tb/cache2w_lookup_test.sv
`timescale 1ns/1ps
module cache2w_lookup_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        busy;
  logic        rsp_valid, rsp_hit, rsp_noalloc;
  logic [31:0] rsp_data;
  logic        fill_req;
  logic [31:0] fill_addr;
  logic        fill_valid;
  logic [31:0] fill_data;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_addr;

  cache2w_lookup uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_noalloc(rsp_noalloc), .rsp_data(rsp_data), .fill_req(fill_req),
    .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model
  bit        m_valid [2][128];
  bit        m_lock  [2][128];
  bit [20:0] m_tag   [2][128];
  bit        m_lru   [128];

  // fill responder state
  bit          stall_mode = 0;
  int          words_sent;
  logic [31:0] seen_fill_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [27:0] line, input int k);
    logic [31:0] v;
    v = {line, k[1:0], 2'b00};
    return (v * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] mk(input int tag, input int idx, input int w);
    return {tag[20:0], idx[6:0], w[1:0], 2'b00};
  endfunction

  // fill responder: one word per cycle, optional gaps
  initial begin
    bit tog;
    int k;
    fill_valid = 0; fill_data = '0; tog = 0; k = 0; words_sent = 0;
    seen_fill_addr = '0;
    forever begin
      @(negedge clk);
      if (fill_req) begin
        seen_fill_addr = fill_addr;
        if (stall_mode && !tog) begin
          fill_valid = 0; tog = 1;
        end else begin
          fill_valid = 1;
          fill_data  = mem_word(fill_addr[31:4], k);
          k++; words_sent++; tog = 0;
        end
      end else begin
        fill_valid = 0; k = 0; tog = 0;
      end
    end
  end

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 100) begin @(negedge clk); t++; end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [31:0] a);
    int idx, w;
    bit hit;
    wait_idle();
    cmd_valid = 1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
    idx = a[10:4]; hit = 0; w = 0;
    for (int i = 0; i < 2; i++)
      if (m_valid[i][idx] && m_tag[i][idx] == a[31:11]) begin hit = 1; w = i; end
    if (hit) begin
      if (op == 2'd1) m_lock[w][idx] = 1;
      if (op == 2'd2) m_lock[w][idx] = 0;
      if (op == 2'd3) begin m_valid[w][idx] = 0; m_lock[w][idx] = 0; end
    end
  endtask

  task automatic do_read(input logic [31:0] a, input string req);
    int idx, w, v, t;
    bit hit, noal;
    logic [31:0] exp;
    idx = a[10:4]; hit = 0; w = 0; noal = 0; v = 0;
    for (int i = 0; i < 2; i++)
      if (m_valid[i][idx] && m_tag[i][idx] == a[31:11]) begin hit = 1; w = i; end
    exp = mem_word(a[31:4], a[3:2]);
    if (hit) m_lru[idx] = ~w[0];
    else begin
      if (m_lock[0][idx] && m_lock[1][idx]) noal = 1;
      else if (m_lock[0][idx]) v = 1;
      else if (m_lock[1][idx]) v = 0;
      else if (!m_valid[0][idx]) v = 0;
      else if (!m_valid[1][idx]) v = 1;
      else v = m_lru[idx];
      if (!noal) begin
        m_valid[v][idx] = 1; m_lock[v][idx] = 0;
        m_tag[v][idx] = a[31:11]; m_lru[idx] = ~v[0];
      end
    end
    wait_idle();
    words_sent = 0;
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    t = 0;
    while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
    chk(rsp_valid, req, "response arrives", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_hit == hit, req, "hit flag", {31'd0, rsp_hit}, {31'd0, hit});
    chk(rsp_noalloc == noal, req, "noalloc flag", {31'd0, rsp_noalloc}, {31'd0, noal});
    chk(rsp_data == exp, req, "data word", rsp_data, exp);
    chk(words_sent == (hit ? 0 : 4), "R2", "fill words used", words_sent, hit ? 0 : 4);
    if (!hit)
      chk(seen_fill_addr == {a[31:4], 4'h0}, "R2", "fill address",
          seen_fill_addr, {a[31:4], 4'h0});
    @(negedge clk);
    chk(!rsp_valid, "R10", "single-cycle response", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset();
    chk(rsp_valid == 0, "R9", "rsp_valid after reset", {31'd0, rsp_valid}, 0);
    chk(fill_req == 0, "R9", "fill_req after reset", {31'd0, fill_req}, 0);
    chk(busy == 0, "R9", "busy after reset", {31'd0, busy}, 0);
    do_read(mk(5, 0, 0), "R9");
  endtask

  task automatic t_fill_and_hit();
    do_read(mk(17, 3, 2), "R2");
    for (int w = 0; w < 4; w++) do_read(mk(17, 3, w) | 32'h3, "R1");
    do_read(mk(17, 3, 2), "R3");
    stall_mode = 1;
    do_read(mk(99, 9, 3), "R2");
    do_read(mk(99, 9, 0), "R3");
    stall_mode = 0;
  endtask

  task automatic t_lru();
    do_read(mk(1, 20, 0), "R4");
    do_read(mk(2, 20, 1), "R4");
    do_read(mk(1, 20, 2), "R4");
    do_read(mk(3, 20, 3), "R4");
    do_read(mk(1, 20, 0), "R4");
    do_read(mk(2, 20, 0), "R4");
    do_read(mk(3, 20, 0), "R4");
  endtask

  task automatic t_lock();
    do_read(mk(10, 40, 0), "R5");
    do_read(mk(11, 40, 0), "R5");
    do_cmd(2'd1, mk(10, 40, 0));
    do_cmd(2'd1, mk(55, 40, 0));
    for (int i = 0; i < 4; i++) do_read(mk(12 + i, 40, i), "R5");
    do_read(mk(10, 40, 1), "R5");
    do_read(mk(13, 40, 3), "R5");
    do_read(mk(14, 40, 2), "R5");
  endtask

  task automatic t_both_locked();
    do_read(mk(20, 60, 0), "R6");
    do_read(mk(21, 60, 0), "R6");
    do_cmd(2'd1, mk(20, 60, 0));
    do_cmd(2'd1, mk(21, 60, 0));
    do_read(mk(22, 60, 1), "R6");
    do_read(mk(22, 60, 3), "R6");
    do_read(mk(20, 60, 2), "R6");
    do_read(mk(21, 60, 2), "R6");
    do_cmd(2'd2, mk(21, 60, 0));
    do_read(mk(21, 60, 1), "R7");
    do_read(mk(22, 60, 0), "R7");
    do_read(mk(22, 60, 1), "R7");
    do_read(mk(20, 60, 0), "R7");
  endtask

  task automatic t_inval();
    do_read(mk(30, 80, 0), "R8");
    do_cmd(2'd0, mk(30, 80, 0));
    do_read(mk(30, 80, 1), "R8");
    do_cmd(2'd1, mk(30, 80, 0));
    do_cmd(2'd3, mk(30, 80, 0));
    do_read(mk(30, 80, 2), "R8");
    do_read(mk(31, 80, 0), "R8");
    do_read(mk(32, 80, 0), "R8");
    // command and request together: command wins, request ignored
    wait_idle();
    cmd_valid = 1; cmd_op = 2'd3; cmd_addr = mk(32, 80, 0);
    req_valid = 1; req_addr = mk(33, 80, 0);
    @(negedge clk);
    cmd_valid = 0; req_valid = 0;
    chk(busy == 0, "R8", "request blocked by command", {31'd0, busy}, 0);
    begin
      int idx = 80;
      for (int i = 0; i < 2; i++)
        if (m_valid[i][idx] && m_tag[i][idx] == 21'd32) begin
          m_valid[i][idx] = 0; m_lock[i][idx] = 0;
        end
    end
    do_read(mk(32, 80, 0), "R8");
  endtask

  task automatic t_sweep();
    logic [31:0] lf = 32'hACE1_1357;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[7:5] == 3'd0)
        do_cmd(lf[9:8], mk(int'(lf[12:10]) % 5, 100 + int'(lf[14:13]), 0));
      else begin
        stall_mode = lf[15];
        do_read(mk(int'(lf[12:10]) % 5, 100 + int'(lf[14:13]), int'(lf[17:16])), "R4");
      end
    end
    stall_mode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      m_lru[i] = 0;
      for (int w = 0; w < 2; w++) begin
        m_valid[w][i] = 0; m_lock[w][i] = 0; m_tag[w][i] = '0;
      end
    end
    rst_n = 0; req_valid = 0; req_addr = '0;
    cmd_valid = 0; cmd_op = 0; cmd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill_and_hit();
    t_lru();
    t_lock();
    t_both_locked();
    t_inval();
    t_sweep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule